// File: doc/BRIEF.md
# Top-Level Pointer Table Loader

This block loads the four top-level pointer entries used by a paging scheme that widens physical addresses to 36 bits. When software writes the control base register while both paging and address extension are enabled, the block takes the upper 27 bits of the written value as a 32-byte aligned table base. It then reads the four 64-bit entries one after another through a simple request/response memory port, with never more than one read in flight.

Each returned entry is checked. An entry is usable only if its present bit is set and every reserved bit is zero. If all four pass, they are copied together into a live register file that a downstream translator indexes to get the 36-bit, 4 KB aligned base of a page directory. If any entry fails, the block raises a one-cycle general-protection fault, and the previously committed entries and the valid flag stay exactly as they were.

Top module: `pdpt_loader`

## Requirements
- R1: Out of reset, `busy`, `valid`, `gp_fault` and `req_valid` are all 0.
- R2: A write on `base_wr` starts a load only when `paging_on` and `ext_addr_on` are both 1. Otherwise it is ignored: no request is issued and `busy` stays 0.
- R3: A load issues exactly four reads, at base, base+8, base+16 and base+24, in that order. The base is `base_wr_data[31:5]` followed by five zero bits. A new request appears only after the previous response. While `req_ready` is 0, a request holds its address.
- R4: `busy` is 1 from the cycle after the accepted trigger until the cycle after the fourth response, when it returns to 0.
- R5: An entry passes only if bit 0 is 1 and bits 1, 2, 5, 6, 7, 8 and 36 to 63 are all 0. Bits 3, 4 and 9 to 35 may hold any value.
- R6: If all four entries pass, they are committed together and `valid` becomes 1 in the cycle after the fourth response. `valid` then stays 1.
- R7: If any entry fails, `gp_fault` is 1 for exactly the one cycle after the fourth response. The committed entries and `valid` are left unchanged.
- R8: A trigger that arrives while `busy` is 1 is ignored. This includes the cycle in which the fourth response arrives.
- R9: `lookup_pd_base` equals bits 35 to 12 of committed entry `lookup_sel`, followed by twelve zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Control base register write strobe |
| base_wr_data | input | 32 | Value written to the control base register |
| paging_on | input | 1 | Paging enable flag |
| ext_addr_on | input | 1 | Physical address extension enable flag |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Byte address of the 64-bit read |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Returned entry |
| busy | output | 1 | Load in progress |
| valid | output | 1 | A committed set of entries exists |
| gp_fault | output | 1 | General-protection fault pulse |
| lookup_sel | input | 2 | Entry index for the translator |
| lookup_pd_base | output | 36 | Page-directory base of the selected entry |

## Verification
The final response of a load and a new control-register write can fall in the same cycle. The bench provokes this by asserting `base_wr`, with a different base, in the same cycle as the fourth `rsp_valid`. It then judges the outcome: the first load must commit exactly as if the write had not occurred, `busy` must drop, and no further request may appear. A second contention is a memory stall landing on a request. Here `req_ready` is held low for several cycles and the bench checks that the request and its address stay put until they are accepted.

// File: rtl/pdpt_pkg.sv
package pdpt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } fetch_state_t;

   // Reserved positions of a top-level pointer entry (R5)
   function automatic bit is_reserved(input int bitpos, input int pa_w);
      return (bitpos == 1) || (bitpos == 2) ||
             (bitpos >= 5 && bitpos <= 8) || (bitpos >= pa_w);
   endfunction
endpackage

// File: rtl/pdpt_entry_check.sv
module pdpt_entry_check #(
   parameter int ENTRY_W = 64,
   parameter int PA_W    = 36
) (
   input  logic [ENTRY_W-1:0] data,
   output logic               bad
);
   function automatic logic [ENTRY_W-1:0] build_mask();
      logic [ENTRY_W-1:0] m;
      for (int i = 0; i < ENTRY_W; i++) m[i] = pdpt_pkg::is_reserved(i, PA_W);
      return m;
   endfunction

   localparam logic [ENTRY_W-1:0] RSV_MASK = build_mask();

   // R5: present bit required, reserved bits must be zero
   assign bad = !data[0] || (|(data & RSV_MASK));
endmodule

// File: rtl/pdpt_fetch_fsm.sv
module pdpt_fetch_fsm #(
   parameter int VA_W    = 32,
   parameter int ENTRIES = 4,
   parameter int ENTRY_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [VA_W-1:0]            start_base,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [VA_W-1:0]            req_addr,
   input  logic                       rsp_valid,
   input  logic                       entry_bad,
   output logic                       wr_en,
   output logic [$clog2(ENTRIES)-1:0] wr_idx,
   output logic                       commit,
   output logic                       fault_now,
   output logic                       busy,
   output logic                       gp_fault
);
   import pdpt_pkg::*;

   localparam int IDX_W    = $clog2(ENTRIES);
   localparam int BYTE_LSB = $clog2(ENTRY_W / 8);
   localparam int BASE_LSB = IDX_W + BYTE_LSB;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   fetch_state_t              st;
   logic [VA_W-1:BASE_LSB]    base_q;
   logic [IDX_W-1:0]          idx;
   logic                      bad_q;
   logic                      fault_q;
   logic                      done;
   logic                      any_bad;
   logic                      unused_base_lo;

   assign unused_base_lo = ^start_base[BASE_LSB-1:0];

   assign req_valid = (st == ST_REQ);
   assign req_addr  = {base_q, idx, {BYTE_LSB{1'b0}}};
   assign wr_en     = (st == ST_WAIT) && rsp_valid;
   assign wr_idx    = idx;
   assign done      = wr_en && (idx == LAST_IDX);
   assign any_bad   = bad_q || entry_bad;
   assign commit    = done && !any_bad;
   assign fault_now = done && any_bad;
   assign busy      = (st != ST_IDLE);
   assign gp_fault  = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         base_q  <= '0;
         idx     <= '0;
         bad_q   <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fault_now;
         case (st)
            ST_IDLE: if (start) begin
               base_q <= start_base[VA_W-1:BASE_LSB];
               idx    <= '0;
               bad_q  <= 1'b0;
               st     <= ST_REQ;
            end
            ST_REQ: if (req_ready) st <= ST_WAIT;
            ST_WAIT: if (rsp_valid) begin
               if (idx == LAST_IDX) begin
                  st <= ST_IDLE;
               end else begin
                  idx   <= idx + 1'b1;
                  bad_q <= any_bad;
                  st    <= ST_REQ;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

   p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |=> !gp_fault);
endmodule

// File: rtl/pdpt_regfile.sv
module pdpt_regfile #(
   parameter int ENTRIES    = 4,
   parameter int ENTRY_W    = 64,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [ENTRY_W-1:0]         wr_data,
   input  logic                       commit,
   input  logic                       fault_now,
   input  logic [$clog2(ENTRIES)-1:0] lookup_sel,
   output logic                       valid,
   output logic [PA_W-1:0]            lookup_base
);
   logic [ENTRY_W-1:0] stage [ENTRIES];
   logic [ENTRY_W-1:0] live  [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage[g] <= '0;
            live[g]  <= '0;
         end else begin
            if (hit) stage[g] <= wr_data;
            if (commit) live[g] <= hit ? wr_data : stage[g];
         end
      end

      p_fault_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
         fault_now |=> (live[g] == $past(live[g])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid <= 1'b0;
      else if (commit) valid <= 1'b1;
   end

   // R9: 4 KB aligned page-directory base
   assign lookup_base = {live[lookup_sel][PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

   p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);

   p_fault_keeps_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_now |=> $stable(valid));
endmodule

// File: rtl/pdpt_loader.sv
module pdpt_loader #(
   parameter int VA_W       = 32,
   parameter int ENTRIES    = 4,
   parameter int ENTRY_W    = 64,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       base_wr,
   input  logic [VA_W-1:0]            base_wr_data,
   input  logic                       paging_on,
   input  logic                       ext_addr_on,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [VA_W-1:0]            req_addr,
   input  logic                       rsp_valid,
   input  logic [ENTRY_W-1:0]         rsp_data,
   output logic                       busy,
   output logic                       valid,
   output logic                       gp_fault,
   input  logic [$clog2(ENTRIES)-1:0] lookup_sel,
   output logic [PA_W-1:0]            lookup_pd_base
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (PA_W > ENTRY_W || PAGE_SHIFT >= PA_W) begin : g_bad_widths
      $error("PA_W must fit in an entry and exceed PAGE_SHIFT");
   end

   logic             start;
   logic             entry_bad;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             commit;
   logic             fault_now;

   // R2: both flags required to start a load
   assign start = base_wr && paging_on && ext_addr_on;

   pdpt_entry_check #(.ENTRY_W(ENTRY_W), .PA_W(PA_W)) u_check (
      .data (rsp_data),
      .bad  (entry_bad)
   );

   pdpt_fetch_fsm #(.VA_W(VA_W), .ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_base (base_wr_data),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .rsp_valid  (rsp_valid),
      .entry_bad  (entry_bad),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .commit     (commit),
      .fault_now  (fault_now),
      .busy       (busy),
      .gp_fault   (gp_fault)
   );

   pdpt_regfile #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .PA_W(PA_W),
                  .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (rsp_data),
      .commit      (commit),
      .fault_now   (fault_now),
      .lookup_sel  (lookup_sel),
      .valid       (valid),
      .lookup_base (lookup_pd_base)
   );

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   p_fault_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> !busy);
endmodule

// File: tb/tb_pdpt_loader.sv
module tb_pdpt_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr = 1'b0;
   logic [31:0] base_wr_data = '0;
   logic        paging_on = 1'b0;
   logic        ext_addr_on = 1'b0;
   logic        req_valid;
   logic        req_ready = 1'b1;
   logic [31:0] req_addr;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        busy;
   logic        valid;
   logic        gp_fault;
   logic [1:0]  lookup_sel = '0;
   logic [35:0] lookup_pd_base;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] model_live [4];
   bit          model_valid = 0;

   always #5 clk = ~clk;

   pdpt_loader dut (
      .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wr_data(base_wr_data),
      .paging_on(paging_on), .ext_addr_on(ext_addr_on), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .busy(busy), .valid(valid), .gp_fault(gp_fault),
      .lookup_sel(lookup_sel), .lookup_pd_base(lookup_pd_base)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit rsv_bit(input int b);
      return (b == 1) || (b == 2) || (b >= 5 && b <= 8) || (b >= 36);
   endfunction

   function automatic bit entry_ok(input logic [63:0] e);
      if (!e[0]) return 0;
      for (int b = 0; b < 64; b++) if (rsv_bit(b) && e[b]) return 0;
      return 1;
   endfunction

   function automatic logic [63:0] mk_entry(input int s);
      logic [23:0] pd;
      pd = 24'(s * 32'h000A_53C1 + 7);
      return {28'h0, pd, 12'h019};
   endfunction

   task automatic check_lookups(input string tag);
      chk(valid == model_valid, {tag, " valid flag"}, 64'(valid), 64'(model_valid));
      for (int i = 0; i < 4; i++) begin
         lookup_sel = 2'(i);
         #1;
         chk(lookup_pd_base == {model_live[i][35:12], 12'h000},
             {tag, " R9 lookup base"}, 64'(lookup_pd_base),
             64'({model_live[i][35:12], 12'h000}));
      end
   endtask

   task automatic run_load(input logic [31:0] base, input logic [63:0] tbl [4],
                           input int stall_k, input int lat, input bit collide);
      bit ok;
      logic [31:0] exp_addr;
      ok = 1;
      for (int i = 0; i < 4; i++) if (!entry_ok(tbl[i])) ok = 0;
      paging_on = 1'b1;
      ext_addr_on = 1'b1;
      base_wr = 1'b1;
      base_wr_data = base;
      @(negedge clk);
      base_wr = 1'b0;
      chk(busy == 1'b1, "R4 busy after trigger", 64'(busy), 64'd1);
      for (int k = 0; k < 4; k++) begin
         int guard;
         guard = 0;
         while (!req_valid && guard < 50) begin
            @(negedge clk);
            guard++;
         end
         exp_addr = {base[31:5], 5'b0} + 32'(8 * k);
         chk(req_valid == 1'b1, "R3 request issued", 64'(req_valid), 64'd1);
         chk(req_addr == exp_addr, "R3 address order", 64'(req_addr), 64'(exp_addr));
         if (k == stall_k) begin
            req_ready = 1'b0;
            repeat (3) @(negedge clk);
            chk(req_valid && req_addr == exp_addr, "R3 request held under stall",
                64'(req_addr), 64'(exp_addr));
            req_ready = 1'b1;
         end
         @(negedge clk);
         chk(req_valid == 1'b0, "R3 single outstanding", 64'(req_valid), 64'd0);
         repeat (lat) @(negedge clk);
         chk(busy == 1'b1, "R4 busy during fetch", 64'(busy), 64'd1);
         rsp_valid = 1'b1;
         rsp_data = tbl[k];
         if (k == 3 && collide) begin
            base_wr = 1'b1;
            base_wr_data = base ^ 32'h0000_0100;
         end
         @(negedge clk);
         rsp_valid = 1'b0;
         rsp_data = '0;
         base_wr = 1'b0;
      end
      chk(busy == 1'b0, "R4 busy released", 64'(busy), 64'd0);
      chk(gp_fault == !ok, ok ? "R6 no fault on good set" : "R7 fault raised",
          64'(gp_fault), 64'(!ok));
      if (ok) begin
         for (int i = 0; i < 4; i++) model_live[i] = tbl[i];
         model_valid = 1;
      end
      check_lookups(ok ? "R6 commit" : "R7 keep old");
      @(negedge clk);
      chk(gp_fault == 1'b0, "R7 fault is one cycle", 64'(gp_fault), 64'd0);
      if (collide) begin
         repeat (3) begin
            chk(!req_valid && !busy, "R8 trigger during final response ignored",
                64'({req_valid, busy}), 64'd0);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] tbl [4];
      for (int i = 0; i < 4; i++) model_live[i] = '0;
      repeat (3) @(negedge clk);
      chk({busy, valid, gp_fault, req_valid} == 4'b0, "R1 reset state",
          64'({busy, valid, gp_fault, req_valid}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, valid, gp_fault, req_valid} == 4'b0, "R1 after reset release",
          64'({busy, valid, gp_fault, req_valid}), 64'd0);

      // R2: flag combinations that must not start a load
      for (int c = 0; c < 3; c++) begin
         paging_on = (c == 1);
         ext_addr_on = (c == 2);
         base_wr = 1'b1;
         base_wr_data = 32'h0000_2000;
         @(negedge clk);
         base_wr = 1'b0;
         repeat (2) begin
            chk(!busy && !req_valid, "R2 trigger ignored without both flags",
                64'({busy, req_valid}), 64'd0);
            @(negedge clk);
         end
      end
      check_lookups("R2 state untouched");

      // First good load, stall on the third request
      for (int i = 0; i < 4; i++) tbl[i] = mk_entry(i + 1);
      run_load(32'h0000_1240, tbl, 2, 1, 0);

      // R5 sweep: flip one bit of one entry per load
      for (int b = 0; b < 64; b++) begin
         for (int i = 0; i < 4; i++) tbl[i] = mk_entry(b * 4 + i + 11);
         tbl[b % 4][b] = ~tbl[b % 4][b];
         chk(entry_ok(tbl[b % 4]) == !(b == 0 || rsv_bit(b)), "R5 bench model",
             64'(entry_ok(tbl[b % 4])), 64'(!(b == 0 || rsv_bit(b))));
         run_load((32'(b) * 32'h0101_0020) & 32'hFFFF_FFE0, tbl,
                  (b % 5 == 0) ? (b % 4) : -1, b % 3, 0);
      end

      // R8: new trigger in the cycle of the final response
      for (int i = 0; i < 4; i++) tbl[i] = mk_entry(i + 500);
      run_load(32'hFFFF_FFE0, tbl, -1, 0, 1);

      // R7: present clear in the last entry keeps the prior set
      for (int i = 0; i < 4; i++) tbl[i] = mk_entry(i + 900);
      tbl[3][0] = 1'b0;
      run_load(32'h0040_0000, tbl, -1, 2, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule